// File: doc/BRIEF.md
# Buffered PWM Reload Controller

This block produces three complementary pairs of PWM outputs from one shared up-counter. Software programs it through a small register port. There are six duty registers, a period modulus register and a control register. The control register holds a two-bit reload rate and one correction-select bit per output pair.

Every register that software writes is a buffer. The counter and the output logic run only from active copies. A scheduler counts finished PWM periods. Every 1, 2, 4 or 8 periods it raises a reload event, and at that event all buffers are copied into the active copies on the same clock edge. A one-cycle strobe marks that event, so firmware can tell when it is safe to stage the next set of values.

Reads always return the buffers, never the active copies. A `REG_OUT` parameter selects combinational PWM outputs (the default) or outputs delayed by one register stage.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset all buffers and active copies are zero. Every address reads 0, `reload_stb` is 1 in every cycle, each pair's first channel is low and its second channel is high.
- R2: Register map for writes and reads:
  - Addresses 0 to 5 hold the duty values for channels 1 to 6.
  - Address 6 is control: bits [1:0] are the reload rate, and bits [4:2] are the correction-select bits for pairs 1, 2 and 3.
  - Address 7 is the period modulus.
  - A read returns the buffered value, with the unused control bits reading 0.
- R3: Reload rate 0, 1, 2 and 3 makes a reload event occur every 1, 2, 4 or 8 PWM periods. `reload_stb` is high for exactly the last cycle of the reload window.
- R4: The counter runs from 0 up to the active modulus M and then returns to 0, so one PWM period lasts M+1 cycles.
- R5: Buffered values have no effect on the outputs or the timing until a reload event. At that event the rate, the correction bits, the modulus and all six duty values become active together on the same edge.
- R6: A newly written rate applies from the reload event after the write. The period count restarts from zero at every reload.
- R7: Each pair's correction bit selects its active value. A value of 0 selects the pair's odd channel register (1, 3 or 5); a value of 1 selects its even channel register (2, 4 or 6).
- R8: The first channel of a pair is 1 while the counter is below the selected active value. The second channel is always its complement. Outputs are bits 0 to 5 of `pwm_out` for channels 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | CNT_W | Buffered contents at rd_addr |
| pwm_out | output | 6 | PWM channels 1 to 6 (bit 0 is channel 1) |
| reload_stb | output | 1 | One-cycle marker of a reload event |

## Verification
A wrong period count or rate copy shows first as a misplaced `reload_stb`. Within one reload window it also shows as a change in the spacing between strobes. A premature or partial copy of the buffers changes the high-time of `pwm_out` within the current window, before the strobe that should have released it. A bad correction or duty copy shows as a wrong high count for a pair within one PWM period after the reload that loads it.

// File: rtl/pwmrl_pkg.sv
package pwmrl_pkg;
   localparam int NPAIR  = 3;
   localparam int NCH    = 2 * NPAIR;
   localparam int ADDR_W = 3;
   localparam int RATE_W = 2;
   localparam int PCNT_W = 3;               // largest divisor is 8 periods
   localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd6;
   localparam logic [ADDR_W-1:0] ADR_MOD  = 3'd7;

   typedef struct packed {
      logic [NPAIR-1:0]  corr;              // bits [4:2]
      logic [RATE_W-1:0] rate;              // bits [1:0]
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
   import pwmrl_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en_i,
   input  logic [ADDR_W-1:0]             wr_addr_i,
   input  logic [CW-1:0]                 wr_data_i,
   input  logic [ADDR_W-1:0]             rd_addr_i,
   output logic [CW-1:0]                 rd_data_o,
   output logic [NCH-1:0][CW-1:0]        buf_duty_o,
   output ctrl_t                         buf_ctrl_o,
   output logic [CW-1:0]                 buf_mod_o
);
   logic [NCH-1:0][CW-1:0] duty_q;
   ctrl_t                  ctrl_q;
   logic [CW-1:0]          mod_q;

   for (genvar g = 0; g < NCH; g++) begin : g_duty
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            duty_q[g] <= '0;
         else if (wr_en_i && wr_addr_i == ADDR_W'(g))
            duty_q[g] <= wr_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mod_q  <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == ADR_CTRL) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
         if (wr_addr_i == ADR_MOD)  mod_q  <= wr_data_i;
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NCH; i++)
         if (rd_addr_i == ADDR_W'(i)) rd_data_o = duty_q[i];
      if (rd_addr_i == ADR_CTRL) rd_data_o = CW'(ctrl_q);
      if (rd_addr_i == ADR_MOD)  rd_data_o = mod_q;
   end

   assign buf_duty_o = duty_q;
   assign buf_ctrl_o = ctrl_q;
   assign buf_mod_o  = mod_q;

   AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == ADR_CTRL) |=> (rd_addr_i != ADR_CTRL ||
         rd_data_o[CTRL_W-1:0] == $past(wr_data_i[CTRL_W-1:0]))); // R2
endmodule

// File: rtl/pwm_active_bank.sv
module pwm_active_bank
   import pwmrl_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reload_i,
   input  logic [NCH-1:0][CW-1:0] buf_duty_i,
   input  ctrl_t                  buf_ctrl_i,
   input  logic [CW-1:0]          buf_mod_i,
   output logic [NCH-1:0][CW-1:0] act_duty_o,
   output ctrl_t                  act_ctrl_o,
   output logic [CW-1:0]          act_mod_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_duty_o <= '0;
         act_ctrl_o <= '0;
         act_mod_o  <= '0;
      end else if (reload_i) begin
         act_duty_o <= buf_duty_i;
         act_ctrl_o <= buf_ctrl_i;
         act_mod_o  <= buf_mod_i;
      end
   end

   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reload_i |=> ($stable(act_duty_o) && $stable(act_ctrl_o) && $stable(act_mod_o))); // R5
   AST_ACT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i |=> (act_ctrl_o == $past(buf_ctrl_i) && act_mod_o == $past(buf_mod_i))); // R5
endmodule

// File: rtl/pwm_reload_sched.sv
module pwm_reload_sched
   import pwmrl_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     mod_act_i,
   input  logic [RATE_W-1:0] rate_act_i,
   output logic [CW-1:0]     cnt_o,
   output logic              reload_o
);
   logic [CW-1:0]     cnt_q;
   logic [PCNT_W-1:0] pcnt_q;
   logic [PCNT_W-1:0] last_period;
   logic              wrap;

   assign last_period = PCNT_W'((1 << rate_act_i) - 1);
   assign wrap        = (cnt_q == mod_act_i);
   assign reload_o    = wrap && (pcnt_q == last_period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pcnt_q <= '0;
      end else begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         if (reload_o)
            pcnt_q <= '0;
         else if (wrap)
            pcnt_q <= pcnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= mod_act_i); // R4
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0)); // R4
   AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= last_period); // R3
   AST_PCNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      reload_o |=> (pcnt_q == '0)); // R6
endmodule

// File: rtl/pwm_pair_out.sv
module pwm_pair_out #(
   parameter int CW = 8
) (
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] val_odd_i,
   input  logic [CW-1:0] val_even_i,
   input  logic          corr_i,
   output logic          hi_o,
   output logic          lo_o
);
   logic [CW-1:0] sel_val;

   assign sel_val = corr_i ? val_even_i : val_odd_i;
   assign hi_o    = (cnt_i < sel_val);
   assign lo_o    = ~hi_o;

   always_comb begin
      if (sel_val == '0) assert (!hi_o); // R8
   end
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
   import pwmrl_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int REG_OUT = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [CNT_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [CNT_W-1:0]     rd_data,
   output logic [NCH-1:0]       pwm_out,
   output logic                 reload_stb
);
   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("CNT_W must hold the control field");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_regout
      $error("REG_OUT must be 0 or 1");
   end

   logic [NCH-1:0][CNT_W-1:0] buf_duty, act_duty;
   ctrl_t                     buf_ctrl, act_ctrl;
   logic [CNT_W-1:0]          buf_mod, act_mod, cnt;
   logic                      reload;
   logic [NCH-1:0]            pwm_raw;

   pwm_regfile #(.CW(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .buf_duty_o(buf_duty), .buf_ctrl_o(buf_ctrl), .buf_mod_o(buf_mod)
   );

   pwm_active_bank #(.CW(CNT_W)) u_active (
      .clk(clk), .rst_n(rst_n), .reload_i(reload),
      .buf_duty_i(buf_duty), .buf_ctrl_i(buf_ctrl), .buf_mod_i(buf_mod),
      .act_duty_o(act_duty), .act_ctrl_o(act_ctrl), .act_mod_o(act_mod)
   );

   pwm_reload_sched #(.CW(CNT_W)) u_sched (
      .clk(clk), .rst_n(rst_n),
      .mod_act_i(act_mod), .rate_act_i(act_ctrl.rate),
      .cnt_o(cnt), .reload_o(reload)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pwm_pair_out #(.CW(CNT_W)) u_pair (
         .cnt_i(cnt),
         .val_odd_i(act_duty[2*p]),
         .val_even_i(act_duty[2*p+1]),
         .corr_i(act_ctrl.corr[p]),
         .hi_o(pwm_raw[2*p]),
         .lo_o(pwm_raw[2*p+1])
      );
   end

   if (REG_OUT == 1) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_out <= '0;
         else        pwm_out <= pwm_raw;
      end
   end else begin : g_out_comb
      assign pwm_out = pwm_raw;
   end

   assign reload_stb = reload;

   AST_STB_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      reload_stb |=> (cnt == '0)); // R3
endmodule

// File: tb/pwm_reload_ctrl_tb.sv
module pwm_reload_ctrl_tb_top;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [CW-1:0] rd_data;
   logic [5:0]    pwm_out;
   logic          reload_stb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   pwm_reload_ctrl #(.CNT_W(CW), .REG_OUT(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pwm_out(pwm_out), .reload_stb(reload_stb)
   );

   // bench model state
   logic [CW-1:0] b_duty [6];
   logic [CW-1:0] a_duty [6];
   logic [1:0]    b_rate, a_rate;
   logic [2:0]    b_corr, a_corr;
   logic [CW-1:0] b_mod, a_mod;
   int            mcnt, mpc;

   function automatic bit exp_stb();
      return (mcnt == int'(a_mod)) && (mpc == (1 << a_rate) - 1);
   endfunction

   function automatic logic [5:0] exp_pwm();
      logic [5:0] r;
      for (int p = 0; p < 3; p++) begin
         logic [CW-1:0] v;
         v = a_corr[p] ? a_duty[2*p+1] : a_duty[2*p];
         r[2*p]   = (mcnt < int'(v));
         r[2*p+1] = !(mcnt < int'(v));
      end
      return r;
   endfunction

   function automatic logic [CW-1:0] exp_rd(input logic [2:0] a);
      if (a < 3'd6) return b_duty[a];
      if (a == 3'd6) return CW'({b_corr, b_rate});
      return b_mod;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 6; i++) begin b_duty[i] = '0; a_duty[i] = '0; end
      b_rate = '0; a_rate = '0; b_corr = '0; a_corr = '0;
      b_mod = '0; a_mod = '0; mcnt = 0; mpc = 0;
   endtask

   task automatic model_step(input bit we, input logic [2:0] wa, input logic [CW-1:0] wd);
      bit evt, wrap;
      wrap = (mcnt == int'(a_mod));
      evt  = exp_stb();
      if (evt) begin
         for (int i = 0; i < 6; i++) a_duty[i] = b_duty[i];
         a_rate = b_rate; a_corr = b_corr; a_mod = b_mod; mpc = 0;
      end else if (wrap) mpc++;
      mcnt = wrap ? 0 : mcnt + 1;
      if (we) begin
         if (wa < 3'd6) b_duty[wa] = wd;
         else if (wa == 3'd6) begin b_rate = wd[1:0]; b_corr = wd[4:2]; end
         else b_mod = wd;
      end
   endtask

   // one clock: drive at negedge, step at posedge, check at next negedge
   task automatic run_cycle(input bit we, input logic [2:0] wa,
                            input logic [CW-1:0] wd, input logic [2:0] ra);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
      @(posedge clk);
      model_step(we, wa, wd);
      @(negedge clk);
      check("R3 reload strobe", 32'(reload_stb), 32'(exp_stb()));
      check("R7/R8 pwm outputs", 32'(pwm_out), 32'(exp_pwm()));
      check("R2 read buffer", 32'(rd_data), 32'(exp_rd(ra)));
   endtask

   // runs until the strobe is seen; first cycle may carry a write
   task automatic measure(input bit we, input logic [2:0] wa, input logic [CW-1:0] wd,
                          output int n, output int hi);
      n = 0; hi = 0;
      run_cycle(we, wa, wd, 3'd0);
      n++; hi += int'(pwm_out[0]);
      while (!reload_stb && n < 1000) begin
         run_cycle(1'b0, 3'd0, '0, 3'd0);
         n++; hi += int'(pwm_out[0]);
      end
   endtask

   initial begin
      int n, hi;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      for (int a = 0; a < 8; a++) begin
         rd_addr = 3'(a);
         #1;
         check("R1 reset read", 32'(rd_data), 32'd0);
      end
      check("R1 reset strobe", 32'(reload_stb), 32'd1);
      check("R1 reset pwm", 32'(pwm_out), 32'b101010);
      for (int a = 0; a < 8; a++) run_cycle(1'b0, 3'd0, '0, 3'(a));

      // modulus 4, duty2 = 1, rate code 2
      run_cycle(1'b1, 3'd7, 8'd4, 3'd7);
      run_cycle(1'b1, 3'd1, 8'd1, 3'd1);
      run_cycle(1'b1, 3'd6, 8'b00010, 3'd6);
      measure(1'b0, 3'd0, '0, n, hi);
      measure(1'b0, 3'd0, '0, n, hi);
      check("R3/R4 window rate2 mod4", 32'(n), 32'd20);
      // R6: new rate only after next reload
      measure(1'b1, 3'd6, 8'b00001, n, hi);
      check("R6 old rate kept", 32'(n), 32'd20);
      measure(1'b0, 3'd0, '0, n, hi);
      check("R6 new rate used", 32'(n), 32'd10);
      // R5: staged duty invisible until reload
      measure(1'b1, 3'd0, 8'd3, n, hi);
      check("R5 duty held", 32'(hi), 32'd0);
      measure(1'b0, 3'd0, '0, n, hi);
      check("R5 duty loaded", 32'(hi), 32'd6);
      // R7: correction bit picks even register
      measure(1'b1, 3'd6, 8'b00101, n, hi);
      check("R7 odd reg still", 32'(hi), 32'd6);
      measure(1'b0, 3'd0, '0, n, hi);
      check("R7 even reg", 32'(hi), 32'd2);
      // rate code 3 with modulus 2: 8 periods of 3
      run_cycle(1'b1, 3'd7, 8'd2, 3'd7);
      measure(1'b1, 3'd6, 8'b00011, n, hi);
      measure(1'b0, 3'd0, '0, n, hi);
      check("R3/R4 window rate3", 32'(n), 32'd24);

      // constrained random
      for (int c = 0; c < 6000; c++) begin
         bit we;
         logic [2:0] wa;
         logic [CW-1:0] wd;
         we = ($urandom % 5) == 0;
         wa = 3'($urandom % 8);
         if (wa == 3'd7) wd = CW'(1 + $urandom % 12);
         else if (wa == 3'd6) wd = CW'($urandom);
         else wd = CW'($urandom % 16);
         run_cycle(we, wa, wd, 3'($urandom % 8));
      end
      wr_en = 1'b0;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule